// File: doc/BRIEF.md
# Single-Precision to Signed Integer Converter

The block takes one single-precision floating-point word per cycle and turns it into a two's-complement integer. A width select picks a 32-bit or a 64-bit result. A 16-bit control word gives the rounding mode, the treat-denormals-as-zero switch and the invalid-operation mask. Each result comes out with two flags. The invalid flag marks inputs that have no integer value: NaN, infinity, or a value outside the chosen range. The inexact flag marks a result that was rounded.

Every input that cannot be represented returns the same indefinite value, the most negative integer of the selected width. The block never saturates toward the nearer bound. When the invalid flag is raised and the mask bit is clear, the block raises an exception request and withholds its write strobe, so the surrounding datapath keeps the old destination value.

The block is a three-stage pipeline. The stages are unpack, align-and-round, and range check with result selection. It accepts a new operand on every cycle and has no back-pressure. Each result appears exactly three clock edges after its operand is taken.

Top module: `f2i_conv`

## Requirements
- R1: A result is presented with `out_valid` high exactly three rising edges after `in_valid` was sampled high, and `out_valid` is low otherwise.
- R2: Inexact results are rounded by control-word bits 14:13: 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R3: With `in_wide` = 0 the valid range is -2^31 to 2^31-1 and the result occupies bits 31:0 with bits 63:32 zero. With `in_wide` = 1 the range is -2^63 to 2^63-1 over all 64 bits. Negative values are two's complement.
- R4: A NaN (quiet or signalling) or an infinity raises `out_invalid` and returns the indefinite value: 0x80000000 in 32-bit mode, 0x8000000000000000 in 64-bit mode.
- R5: The range test applies to the rounded value. A rounded value outside the selected range raises `out_invalid` and returns the indefinite value.
- R6: `out_inexact` is high when rounding discarded nonzero fraction bits and the input is not invalid. It is never high together with `out_invalid`.
- R7: With control-word bit 6 set, a denormal input converts as zero, exactly, in every rounding mode. With it clear, a denormal is a tiny nonzero value that rounds under R2.
- R8: Control-word bit 15 (flush-to-zero) has no effect on result or flags.
- R9: Control-word bit 7 masks the invalid exception. When `out_invalid` is raised with the mask clear, `out_trap` is high and `out_write` is low. Otherwise a valid result has `out_write` high and `out_trap` low.
- R10: During and after reset, before any operand, `out_valid`, `out_write`, `out_trap` and both flags are low.
- R11: Operands on consecutive cycles each produce their own result on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_value | input | 32 | Single-precision operand |
| in_wide | input | 1 | 1 selects a 64-bit result, 0 a 32-bit result |
| in_ctrl | input | 16 | Control word: rounding mode 14:13, flush 15, denormal-as-zero 6, invalid mask 7 |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 64 | Integer result, zero-extended in 32-bit mode |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Precision flag |
| out_trap | output | 1 | Unmasked invalid exception request |
| out_write | output | 1 | Result may be written to the destination |

## Verification
The checker watches a fixed set of properties on every cycle. These are the three-cycle valid timing, zero upper bits in 32-bit mode, and the indefinite value on every masked invalid result. It also checks that the invalid and inexact flags are never both high, that the trap and write strobes are consistent, and that the outputs are silent when no result is present. The bench's scenarios are the only place the arithmetic itself is tested. These cover the four rounding directions on ties and on sub-half fractions, the exact range endpoints of both widths, the denormal switch, the ignored flush bit, and a back-to-back burst.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    localparam int SP_W     = 32;
    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;
    localparam int MANT_W   = FRAC_W + 1;
    localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_S_W  = EXP_W + 2;
    localparam int WIDE_W   = 64;
    localparam int NARROW_W = 32;
    localparam int FIX_W    = 2 * WIDE_W;
    localparam int SH_W     = $clog2(FIX_W);
    localparam int CTRL_W   = 16;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_t;

    typedef struct packed {
        logic              neg;
        logic [EXP_S_W-1:0] exp_u;
        logic [MANT_W-1:0] mant;
        logic              special;
        logic              wide;
        rmode_t            rm;
        logic              mask;
    } unp_t;

    typedef struct packed {
        logic              neg;
        logic [WIDE_W:0]   mag;
        logic              inexact;
        logic              huge;
        logic              special;
        logic              wide;
        logic              mask;
    } rnd_t;

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_in,
    input  logic [SP_W-1:0]   value,
    input  logic              wide,
    input  logic [1:0]        rc,
    input  logic              daz,
    input  logic              mask,
    output logic              v_out,
    output unp_t              d_out
);

    logic [EXP_W-1:0]  biased;
    logic [FRAC_W-1:0] frac;
    unp_t              nxt;

    assign biased = value[SP_W-2 -: EXP_W];
    assign frac   = value[FRAC_W-1:0];

    always_comb begin
        nxt         = '0;
        nxt.neg     = value[SP_W-1];
        nxt.special = (biased == '1);
        nxt.wide    = wide;
        nxt.rm      = rmode_t'(rc);
        nxt.mask    = mask;
        if (biased == '0) begin
            nxt.exp_u = EXP_S_W'(1 - BIAS);
            nxt.mant  = (daz || frac == '0) ? '0 : {1'b0, frac};
        end else begin
            nxt.exp_u = EXP_S_W'({2'b00, biased}) - EXP_S_W'(BIAS);
            nxt.mant  = {1'b1, frac};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_out <= 1'b0;
            d_out <= '0;
        end else begin
            v_out <= v_in;
            if (v_in) d_out <= nxt;
        end
    end

endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic v_in,
    input  unp_t d_in,
    output logic v_out,
    output rnd_t d_out
);

    localparam logic signed [EXP_S_W-1:0] E_LIMIT = EXP_S_W'(WIDE_W);
    localparam logic signed [EXP_S_W-1:0] E_HALF  = '1;

    logic              huge;
    logic [SH_W-1:0]   sh;
    logic [FIX_W-1:0]  fixed_pt;
    logic [WIDE_W-1:0] ipart;
    logic              rbit;
    logic              sticky;
    logic              inc;
    rnd_t              nxt;

    assign huge = $signed(d_in.exp_u) >= E_LIMIT;
    assign sh   = d_in.exp_u[SH_W-1:0] + SH_W'(WIDE_W - FRAC_W);

    always_comb begin
        fixed_pt = '0;
        ipart    = '0;
        rbit     = 1'b0;
        sticky   = 1'b0;
        if ($signed(d_in.exp_u) < E_HALF) begin
            sticky = |d_in.mant;
        end else if (!huge) begin
            fixed_pt = FIX_W'(d_in.mant) << sh;
            ipart    = fixed_pt[FIX_W-1:WIDE_W];
            rbit     = fixed_pt[WIDE_W-1];
            sticky   = |fixed_pt[WIDE_W-2:0];
        end
        unique case (d_in.rm)
            RM_NEAR: inc = rbit & (sticky | ipart[0]);
            RM_DOWN: inc = d_in.neg & (rbit | sticky);
            RM_UP:   inc = ~d_in.neg & (rbit | sticky);
            RM_ZERO: inc = 1'b0;
            default: inc = 1'b0;
        endcase
        nxt         = '0;
        nxt.neg     = d_in.neg;
        nxt.mag     = {1'b0, ipart} + (WIDE_W+1)'(inc);
        nxt.inexact = rbit | sticky;
        nxt.huge    = huge;
        nxt.special = d_in.special;
        nxt.wide    = d_in.wide;
        nxt.mask    = d_in.mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_out <= 1'b0;
            d_out <= '0;
        end else begin
            v_out <= v_in;
            if (v_in) d_out <= nxt;
        end
    end

endmodule

// File: rtl/f2i_pack.sv
module f2i_pack
    import f2i_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_in,
    input  rnd_t              d_in,
    output logic              v_out,
    output logic [WIDE_W-1:0] result,
    output logic              invalid,
    output logic              inexact,
    output logic              trap,
    output logic              write_en
);

    localparam logic [WIDE_W:0] LIM_WIDE   = ((WIDE_W+1)'(1) << (WIDE_W - 1)) - (WIDE_W+1)'(1);
    localparam logic [WIDE_W:0] LIM_NARROW = ((WIDE_W+1)'(1) << (NARROW_W - 1)) - (WIDE_W+1)'(1);
    localparam logic [WIDE_W-1:0] IND_WIDE   = WIDE_W'(1) << (WIDE_W - 1);
    localparam logic [WIDE_W-1:0] IND_NARROW = WIDE_W'(1) << (NARROW_W - 1);

    logic [WIDE_W:0]   lim;
    logic              over;
    logic              inv;
    logic [WIDE_W-1:0] sval;
    logic [WIDE_W-1:0] res;

    always_comb begin
        lim  = (d_in.wide ? LIM_WIDE : LIM_NARROW) + (WIDE_W+1)'(d_in.neg);
        over = d_in.mag > lim;
        inv  = d_in.special | d_in.huge | over;
        sval = d_in.neg ? (~d_in.mag[WIDE_W-1:0] + 1'b1) : d_in.mag[WIDE_W-1:0];
        if (inv)
            res = d_in.wide ? IND_WIDE : IND_NARROW;
        else if (d_in.wide)
            res = sval;
        else
            res = {{(WIDE_W-NARROW_W){1'b0}}, sval[NARROW_W-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_out    <= 1'b0;
            result   <= '0;
            invalid  <= 1'b0;
            inexact  <= 1'b0;
            trap     <= 1'b0;
            write_en <= 1'b0;
        end else begin
            v_out    <= v_in;
            invalid  <= v_in & inv;
            inexact  <= v_in & d_in.inexact & ~inv;
            trap     <= v_in & inv & ~d_in.mask;
            write_en <= v_in & ~(inv & ~d_in.mask);
            if (v_in) result <= res;
        end
    end

endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
    import f2i_pkg::*;
#(
    parameter int RC_LSB  = 13,
    parameter int DAZ_BIT = 6,
    parameter int IM_BIT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SP_W-1:0]   in_value,
    input  logic              in_wide,
    input  logic [CTRL_W-1:0] in_ctrl,
    output logic              out_valid,
    output logic [WIDE_W-1:0] out_result,
    output logic              out_invalid,
    output logic              out_inexact,
    output logic              out_trap,
    output logic              out_write
);

    logic ctrl_unused;
    logic v1, v2;
    unp_t s1;
    rnd_t s2;

    assign ctrl_unused = ^in_ctrl;

    f2i_unpack u_unpack (
        .clk   (clk),
        .rst_n (rst_n),
        .v_in  (in_valid),
        .value (in_value),
        .wide  (in_wide),
        .rc    (in_ctrl[RC_LSB +: 2]),
        .daz   (in_ctrl[DAZ_BIT]),
        .mask  (in_ctrl[IM_BIT]),
        .v_out (v1),
        .d_out (s1)
    );

    f2i_round u_round (
        .clk   (clk),
        .rst_n (rst_n),
        .v_in  (v1),
        .d_in  (s1),
        .v_out (v2),
        .d_out (s2)
    );

    f2i_pack u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .v_in     (v2),
        .d_in     (s2),
        .v_out    (out_valid),
        .result   (out_result),
        .invalid  (out_invalid),
        .inexact  (out_inexact),
        .trap     (out_trap),
        .write_en (out_write)
    );

endmodule

// File: rtl/f2i_checks.sv
module f2i_checks
    import f2i_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_wide,
    input logic              out_valid,
    input logic [WIDE_W-1:0] out_result,
    input logic              out_invalid,
    input logic              out_inexact,
    input logic              out_trap,
    input logic              out_write
);

    logic [2:0] vq;
    logic [2:0] wq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vq <= '0;
            wq <= '0;
        end else begin
            vq <= {vq[1:0], in_valid};
            wq <= {wq[1:0], in_wide};
        end
    end

    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vq[2]);

    a_r3_narrow_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !wq[2]) |-> (out_result[WIDE_W-1:NARROW_W] == '0));

    a_r4_indefinite: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid && out_write) |->
        (out_result == (wq[2] ? (WIDE_W'(1) << (WIDE_W-1)) : (WIDE_W'(1) << (NARROW_W-1)))));

    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_invalid && out_inexact));

    a_r9_trap_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (out_invalid && !out_write));

    a_r9_valid_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_invalid) |-> out_write);

    a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_write && !out_trap && !out_invalid && !out_inexact));

endmodule

bind f2i_conv f2i_checks u_chk (.*);

// File: tb/sim_f2i_conv.sv
`timescale 1ns/1ps
module sim_f2i_conv;

    typedef struct packed {
        logic [31:0] val;
        logic        wide;
        logic [15:0] ctrl;
        logic [63:0] res;
        logic        inv;
        logic        inx;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    // ctrl: bit7 mask set; rounding 0x0080 near, 0x2080 down, 0x4080 up, 0x6080 zero
    localparam vec_t VECS [NV] = '{
        '{32'h3FC00000, 1'b0, 16'h0080, 64'h2,                 1'b0, 1'b1, 4'd2},  // R2 1.5 near -> 2
        '{32'h40200000, 1'b0, 16'h0080, 64'h2,                 1'b0, 1'b1, 4'd2},  // R2 2.5 near -> 2
        '{32'hBFC00000, 1'b0, 16'h2080, 64'h00000000FFFFFFFE,  1'b0, 1'b1, 4'd2},  // R2 -1.5 down
        '{32'hBFC00000, 1'b0, 16'h4080, 64'h00000000FFFFFFFF,  1'b0, 1'b1, 4'd2},  // R2 -1.5 up
        '{32'hBFC00000, 1'b0, 16'h6080, 64'h00000000FFFFFFFF,  1'b0, 1'b1, 4'd2},  // R2 -1.5 zero
        '{32'h3FC00000, 1'b0, 16'h4080, 64'h2,                 1'b0, 1'b1, 4'd2},  // R2 1.5 up
        '{32'h3FC00000, 1'b0, 16'h2080, 64'h1,                 1'b0, 1'b1, 4'd2},  // R2 1.5 down
        '{32'h42C80000, 1'b0, 16'h0080, 64'h64,                1'b0, 1'b0, 4'd6},  // R6 100 exact
        '{32'hCF000000, 1'b0, 16'h0080, 64'h0000000080000000,  1'b0, 1'b0, 4'd3},  // R3 -2^31 fits
        '{32'h4F000000, 1'b0, 16'h0080, 64'h0000000080000000,  1'b1, 1'b0, 4'd5},  // R5 2^31 narrow
        '{32'h4F000000, 1'b1, 16'h0080, 64'h0000000080000000,  1'b0, 1'b0, 4'd3},  // R3 2^31 wide
        '{32'h7FC00000, 1'b1, 16'h0080, 64'h8000000000000000,  1'b1, 1'b0, 4'd4},  // R4 qNaN
        '{32'hFF800000, 1'b0, 16'h0080, 64'h0000000080000000,  1'b1, 1'b0, 4'd4},  // R4 -inf
        '{32'hDF000000, 1'b1, 16'h0080, 64'h8000000000000000,  1'b0, 1'b0, 4'd3},  // R3 -2^63 fits
        '{32'h5F000000, 1'b1, 16'h0080, 64'h8000000000000000,  1'b1, 1'b0, 4'd5},  // R5 2^63 wide
        '{32'h3E800000, 1'b0, 16'h4080, 64'h1,                 1'b0, 1'b1, 4'd2},  // R2 0.25 up
        '{32'h3E800000, 1'b0, 16'h0080, 64'h0,                 1'b0, 1'b1, 4'd6},  // R6 0.25 near
        '{32'hBE800000, 1'b1, 16'h2080, 64'hFFFFFFFFFFFFFFFF,  1'b0, 1'b1, 4'd3},  // R3 -0.25 down wide
        '{32'h3F000000, 1'b0, 16'h0080, 64'h0,                 1'b0, 1'b1, 4'd2},  // R2 0.5 tie even
        '{32'h00000001, 1'b0, 16'h4080, 64'h1,                 1'b0, 1'b1, 4'd7},  // R7 denormal up
        '{32'h00000001, 1'b0, 16'h40C0, 64'h0,                 1'b0, 1'b0, 4'd7},  // R7 denormal as zero
        '{32'h80000001, 1'b1, 16'h20C0, 64'h0,                 1'b0, 1'b0, 4'd7},  // R7 -denormal as zero down
        '{32'h3FC00000, 1'b0, 16'h8080, 64'h2,                 1'b0, 1'b1, 4'd8},  // R8 flush bit set
        '{32'h80000000, 1'b1, 16'h2080, 64'h0,                 1'b0, 1'b0, 4'd6},  // R6 -0
        '{32'h4EFFFFFF, 1'b0, 16'h6080, 64'h000000007FFFFF80,  1'b0, 1'b0, 4'd3},  // R3 largest below 2^31
        '{32'h7F800001, 1'b0, 16'h6080, 64'h0000000080000000,  1'b1, 1'b0, 4'd4},  // R4 sNaN
        '{32'hC2C80000, 1'b1, 16'h0080, 64'hFFFFFFFFFFFFFF9C,  1'b0, 1'b0, 4'd3},  // R3 -100 wide
        '{32'h7F7FFFFF, 1'b1, 16'h0080, 64'h8000000000000000,  1'b1, 1'b0, 4'd5}   // R5 max float
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_value = '0;
    logic        in_wide = 1'b0;
    logic [15:0] in_ctrl = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_invalid;
    logic        out_inexact;
    logic        out_trap;
    logic        out_write;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    f2i_conv u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
        .in_wide(in_wide), .in_ctrl(in_ctrl), .out_valid(out_valid),
        .out_result(out_result), .out_invalid(out_invalid), .out_inexact(out_inexact),
        .out_trap(out_trap), .out_write(out_write)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] v, input logic w, input logic [15:0] c);
        in_valid = 1'b1;
        in_value = v;
        in_wide  = w;
        in_ctrl  = c;
    endtask

    task automatic check_out(input string tag, input logic [63:0] r,
                             input logic inv, input logic inx);
        chk({tag, " valid"},   64'(out_valid), 64'd1);
        chk({tag, " result"},  out_result, r);
        chk({tag, " invalid"}, 64'(out_invalid), 64'(inv));
        chk({tag, " inexact"}, 64'(out_inexact), 64'(inx));
        chk({tag, " write"},   64'(out_write), 64'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 valid in reset", 64'(out_valid), 64'd0);
        chk("R10 write in reset", 64'(out_write), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle after reset", 64'({out_valid, out_write, out_trap, out_invalid, out_inexact}), 64'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].val, VECS[i].wide, VECS[i].ctrl);
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            @(negedge clk);
            check_out($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].res, VECS[i].inv, VECS[i].inx);
            chk($sformatf("R9 vec%0d trap", i), 64'(out_trap), 64'd0);
        end

        // R1 latency: not early, exactly at third edge, one cycle wide
        drive(32'h42C80000, 1'b0, 16'h0080);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R1 not at second edge", 64'(out_valid), 64'd0);
        @(negedge clk);
        chk("R1 at third edge", 64'(out_valid), 64'd1);
        @(negedge clk);
        chk("R1 single cycle", 64'(out_valid), 64'd0);

        // R9 unmasked invalid
        drive(32'h7FC00000, 1'b1, 16'h0000);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 trap raised", 64'(out_trap), 64'd1);
        chk("R9 write withheld", 64'(out_write), 64'd0);
        chk("R9 invalid flag", 64'(out_invalid), 64'd1);

        // R9 mask clear but valid input writes normally
        drive(32'h3FC00000, 1'b0, 16'h0000);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 no trap on valid", 64'(out_trap), 64'd0);
        check_out("R9 unmasked valid", 64'h2, 1'b0, 1'b1);

        // R11 back-to-back burst
        drive(32'h3FC00000, 1'b0, 16'h0080);
        @(negedge clk);
        drive(32'h42C80000, 1'b1, 16'h6080);
        @(negedge clk);
        drive(32'hBFC00000, 1'b0, 16'h2080);
        @(negedge clk);
        in_valid = 1'b0;
        check_out("R11 burst 0", 64'h2, 1'b0, 1'b1);
        @(negedge clk);
        check_out("R11 burst 1", 64'h64, 1'b0, 1'b0);
        @(negedge clk);
        check_out("R11 burst 2", 64'h00000000FFFFFFFE, 1'b0, 1'b1);
        @(negedge clk);
        chk("R11 burst end", 64'(out_valid), 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule